// File: doc/BRIEF.md
# Service-Mode Register Write/Verify Sequencer

This block runs one address-register write or verify on an isolated programming track, from the command-station side. After a `start` pulse it switches track power on and walks through fixed phases. Each phase offers a minimum number of packets to a downstream bit serializer through a ready/valid handshake. Each packet carries a kind code and three payload bytes. For the whole session the block asks the serializer for the long preamble.

The phases run in this order:
- a power-up burst of idle packets;
- decoder resets;
- page-preset packets, followed by a filler run of page-presets;
- an optional interval with track power removed;
- a second group of resets;
- the write or verify packets aimed at the address register.

An acknowledge from the decoder during the write/verify packets cuts that phase short. The block then sends a run of recovery resets and reports success. If no acknowledge arrives, the block sends a fixed run of identical trailing packets and then reports completion. The success flag is clear unless an acknowledge was seen during those trailing packets. The packet counts therefore act as a bounded timeout in place of an open-ended wait.

Top module: `svc_prog_seq`

## Requirements
- R1: Out of reset, and whenever no run is in progress, `busy`, `done`, `pktValid` and `trackPowerEn` are low.
- R2: After `start`, `trackPowerEn` goes high and the first 20 accepted packets are idle packets: kind 0, bytes FF 00 FF.
- R3: Next come 3 reset packets (kind 1, bytes 00 00 00), then 11 page-preset packets (5 preset plus 6 filler; kind 2, bytes 7D 01 7C). Byte 2 of every packet is the XOR of bytes 0 and 1.
- R4: With the power-cycle option captured as set, the page-preset packets are followed by max(`offClocks`,1) clocks with `trackPowerEn` low and no packet offered. With the option clear, `trackPowerEn` stays high for the whole run.
- R5: Then 3 reset packets, then program packets. A write is kind 3 with bytes 78, data, XOR. A verify is kind 4 with bytes 70, data, XOR. Mode and data are captured at `start`.
- R6: If no acknowledge arrives, exactly 5 program packets are followed by 10 identical program packets. Then `done` pulses with `success` low.
- R7: If `ack` is high in the cycle that the j-th program packet is accepted (j from 1 to 5), no further program packet follows. The block sends 10 reset packets, then pulses `done` with `success` high.
- R8: If `ack` is high while one of the 10 trailing program packets is accepted, all 10 are still sent, and `done` then pulses with `success` high.
- R9: `longPreamble` is high whenever `pktValid` is high.
- R10: While `pktValid` is high and `pktReady` is low, `pktValid`, the kind and the bytes hold steady. The phase advances only on accepted packets.
- R11: `done` is a one-cycle pulse with `busy` low. `success` keeps its value until the next run completes.
- R12: A `start` pulse while `busy` is high is ignored. The run in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (pulse, honoured only when idle) |
| progVerify | input | 1 | 1 = verify packets, 0 = write packets |
| pwrCycleEn | input | 1 | Insert the power-off interval |
| offClocks | input | OFF_W | Length of the power-off interval in clocks |
| regValue | input | 8 | Value written to or compared against the address register |
| ack | input | 1 | Decoder acknowledge, already detected and synchronised |
| pktReady | input | 1 | Serializer accepts the offered packet |
| pktValid | output | 1 | Packet offered |
| pktKind | output | 3 | Packet kind code |
| pktByte0 | output | 8 | First payload byte |
| pktByte1 | output | 8 | Second payload byte |
| pktByte2 | output | 8 | Check byte |
| longPreamble | output | 1 | Serializer must use the long preamble |
| trackPowerEn | output | 1 | Programming track power enable |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| success | output | 1 | Acknowledge observed in the last run |

## Verification
Two events can fall in the same cycle: a decoder acknowledge, and the handshake that accepts a program packet. The sharpest case is the acceptance of the fifth and last program packet, where the phase would end in any case. The bench raises `ack` exactly in the accepting cycle of the j-th program packet. It sweeps j across the cut-short range, the last-packet boundary, the trailing range and beyond, under three `pktReady` patterns. For each case it judges the packet-by-packet kind sequence, the count of program packets, the kind of the trailing packets and the final `success` value against figures derived from j.

// File: rtl/svc_prog_pkg.sv
package svc_prog_pkg;

  typedef enum logic [2:0] {
    KIND_IDLE   = 3'd0,
    KIND_RESET  = 3'd1,
    KIND_PAGE   = 3'd2,
    KIND_WRITE  = 3'd3,
    KIND_VERIFY = 3'd4
  } pktKind_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PWRUP, ST_RST1, ST_PAGE, ST_FILL, ST_OFF,
    ST_RST2, ST_PROG, ST_TAIL, ST_RECOV, ST_DONE
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic cntInc;
    logic cntClr;
    logic offInc;
    logic offClr;
    logic ackArm;
    logic ackClr;
    logic succLoad;
    logic succVal;
  } seqStrobe_t;

  localparam logic [7:0] OP_IDLE   = 8'hFF;
  localparam logic [7:0] OP_PAGE   = 8'h7D;
  localparam logic [7:0] PAGE_ONE  = 8'h01;
  localparam logic [7:0] OP_WRITE  = 8'h78; // write, register field 0 (address)
  localparam logic [7:0] OP_VERIFY = 8'h70; // verify, register field 0

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic [23:0] makePayload(input pktKind_e k, input logic [7:0] data);
    logic [7:0] b0;
    logic [7:0] b1;
    case (k)
      KIND_IDLE:   begin b0 = OP_IDLE;   b1 = 8'h00;    end
      KIND_PAGE:   begin b0 = OP_PAGE;   b1 = PAGE_ONE; end
      KIND_WRITE:  begin b0 = OP_WRITE;  b1 = data;     end
      KIND_VERIFY: begin b0 = OP_VERIFY; b1 = data;     end
      default:     begin b0 = 8'h00;     b1 = 8'h00;    end
    endcase
    return {b0, b1, b0 ^ b1};
  endfunction

endpackage

// File: rtl/svc_prog_dp.sv
module svc_prog_dp
  import svc_prog_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int OFF_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       stb,
  input  pktKind_e         kind,
  input  logic             ack,
  input  logic             progVerifyIn,
  input  logic             pwrCycleEnIn,
  input  logic [OFF_W-1:0] offClocksIn,
  input  logic [7:0]       regValueIn,
  output logic [CNT_W-1:0] cnt,
  output logic             offDone,
  output logic             ackFlag,
  output logic             modeVerify,
  output logic             cycleEn,
  output logic             success,
  output logic [7:0]       pktByte0,
  output logic [7:0]       pktByte1,
  output logic [7:0]       pktByte2
);

  logic [OFF_W-1:0] offCnt;
  logic [OFF_W-1:0] offLimit;
  logic [7:0]       dataReg;
  logic [23:0]      payload;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt        <= '0;
      offCnt     <= '0;
      offLimit   <= '0;
      dataReg    <= '0;
      ackFlag    <= 1'b0;
      modeVerify <= 1'b0;
      cycleEn    <= 1'b0;
      success    <= 1'b0;
    end else begin
      if (stb.capture) begin
        modeVerify <= progVerifyIn;
        cycleEn    <= pwrCycleEnIn;
        offLimit   <= offClocksIn;
        dataReg    <= regValueIn;
      end
      if (stb.cntClr)      cnt <= '0;
      else if (stb.cntInc) cnt <= cnt + 1'b1;
      if (stb.offClr)      offCnt <= '0;
      else if (stb.offInc) offCnt <= offCnt + 1'b1;
      if (stb.ackClr)                ackFlag <= 1'b0;
      else if (stb.ackArm && ack)    ackFlag <= 1'b1;
      if (stb.succLoad) success <= stb.succVal;
    end
  end

  // a zero length is treated as one clock
  assign offDone = ({1'b0, offCnt} + (OFF_W+1)'(1)) >= {1'b0, offLimit};

  assign payload  = makePayload(kind, dataReg);
  assign pktByte0 = payload[23:16];
  assign pktByte1 = payload[15:8];
  assign pktByte2 = payload[7:0];

endmodule

// File: rtl/svc_prog_ctrl.sv
module svc_prog_ctrl
  import svc_prog_pkg::*;
#(
  parameter int PWRUP_CNT = 20,
  parameter int RST1_CNT  = 3,
  parameter int PAGE_CNT  = 5,
  parameter int FILL_CNT  = 6,
  parameter int RST2_CNT  = 3,
  parameter int PROG_CNT  = 5,
  parameter int TAIL_CNT  = 10,
  parameter int CNT_W     = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             modeVerify,
  input  logic             cycleEn,
  input  logic             accept,
  input  logic             ack,
  input  logic             ackFlag,
  input  logic             offDone,
  input  logic [CNT_W-1:0] cnt,
  output seqState_e        state,
  output pktKind_e         kind,
  output logic             offer,
  output seqStrobe_t       stb
);

  seqState_e  nxt;
  seqState_e  follow;
  logic [CNT_W-1:0] lim;
  logic       lastPkt;
  pktKind_e   progKind;

  assign progKind = modeVerify ? KIND_VERIFY : KIND_WRITE;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  // per-phase packet count and successor
  always_comb begin
    lim    = CNT_W'(1);
    follow = ST_IDLE;
    kind   = KIND_IDLE;
    offer  = 1'b0;
    case (state)
      ST_PWRUP: begin lim = CNT_W'(PWRUP_CNT); follow = ST_RST1; kind = KIND_IDLE;  offer = 1'b1; end
      ST_RST1:  begin lim = CNT_W'(RST1_CNT);  follow = ST_PAGE; kind = KIND_RESET; offer = 1'b1; end
      ST_PAGE:  begin lim = CNT_W'(PAGE_CNT);  follow = ST_FILL; kind = KIND_PAGE;  offer = 1'b1; end
      ST_FILL:  begin
        lim    = CNT_W'(FILL_CNT);
        follow = cycleEn ? ST_OFF : ST_RST2;
        kind   = KIND_PAGE;
        offer  = 1'b1;
      end
      ST_RST2:  begin lim = CNT_W'(RST2_CNT);  follow = ST_PROG; kind = KIND_RESET; offer = 1'b1; end
      ST_PROG:  begin lim = CNT_W'(PROG_CNT);  follow = ST_TAIL; kind = progKind;   offer = 1'b1; end
      ST_TAIL:  begin lim = CNT_W'(TAIL_CNT);  follow = ST_DONE; kind = progKind;   offer = 1'b1; end
      ST_RECOV: begin lim = CNT_W'(TAIL_CNT);  follow = ST_DONE; kind = KIND_RESET; offer = 1'b1; end
      default:  ;
    endcase
  end

  assign lastPkt = (cnt == lim - 1'b1);

  always_comb begin
    nxt        = state;
    stb        = '0;
    stb.ackArm = (state == ST_PROG) || (state == ST_TAIL);
    case (state)
      ST_IDLE: begin
        if (start) begin
          nxt         = ST_PWRUP;
          stb.capture = 1'b1;
          stb.cntClr  = 1'b1;
          stb.ackClr  = 1'b1;
        end
      end
      ST_OFF: begin
        stb.offInc = 1'b1;
        if (offDone) begin
          nxt        = ST_RST2;
          stb.offClr = 1'b1;
          stb.cntClr = 1'b1;
        end
      end
      ST_DONE: nxt = ST_IDLE;
      default: begin
        if (accept) begin
          if (state == ST_PROG && (ackFlag || ack)) begin
            nxt        = ST_RECOV;
            stb.cntClr = 1'b1;
          end else if (lastPkt) begin
            nxt        = follow;
            stb.cntClr = 1'b1;
            stb.offClr = (follow == ST_OFF);
            if (follow == ST_DONE) begin
              stb.succLoad = 1'b1;
              stb.succVal  = (state == ST_RECOV) ? 1'b1 : (ackFlag || ack);
            end
          end else begin
            stb.cntInc = 1'b1;
          end
        end
      end
    endcase
  end

endmodule

// File: rtl/svc_prog_seq.sv
module svc_prog_seq
  import svc_prog_pkg::*;
#(
  parameter int PWRUP_CNT = 20,
  parameter int RST1_CNT  = 3,
  parameter int PAGE_CNT  = 5,
  parameter int FILL_CNT  = 6,
  parameter int RST2_CNT  = 3,
  parameter int PROG_CNT  = 5,
  parameter int TAIL_CNT  = 10,
  parameter int OFF_W     = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             progVerify,
  input  logic             pwrCycleEn,
  input  logic [OFF_W-1:0] offClocks,
  input  logic [7:0]       regValue,
  input  logic             ack,
  input  logic             pktReady,
  output logic             pktValid,
  output logic [2:0]       pktKind,
  output logic [7:0]       pktByte0,
  output logic [7:0]       pktByte1,
  output logic [7:0]       pktByte2,
  output logic             longPreamble,
  output logic             trackPowerEn,
  output logic             busy,
  output logic             done,
  output logic             success
);

  localparam int MAX_CNT = maxOf(maxOf(maxOf(PWRUP_CNT, RST1_CNT), maxOf(PAGE_CNT, FILL_CNT)),
                                 maxOf(maxOf(RST2_CNT, PROG_CNT), TAIL_CNT));
  localparam int CNT_W   = $clog2(MAX_CNT + 1);

  seqState_e        state;
  pktKind_e         kind;
  seqStrobe_t       stb;
  logic             offer;
  logic             accept;
  logic [CNT_W-1:0] cnt;
  logic             offDone;
  logic             ackFlag;
  logic             modeVerify;
  logic             cycleEn;

  assign accept = offer && pktReady;

  svc_prog_ctrl #(
    .PWRUP_CNT(PWRUP_CNT), .RST1_CNT(RST1_CNT), .PAGE_CNT(PAGE_CNT), .FILL_CNT(FILL_CNT),
    .RST2_CNT(RST2_CNT), .PROG_CNT(PROG_CNT), .TAIL_CNT(TAIL_CNT), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .modeVerify(modeVerify), .cycleEn(cycleEn),
    .accept(accept), .ack(ack), .ackFlag(ackFlag), .offDone(offDone), .cnt(cnt),
    .state(state), .kind(kind), .offer(offer), .stb(stb)
  );

  svc_prog_dp #(.CNT_W(CNT_W), .OFF_W(OFF_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .kind(kind), .ack(ack),
    .progVerifyIn(progVerify), .pwrCycleEnIn(pwrCycleEn), .offClocksIn(offClocks),
    .regValueIn(regValue), .cnt(cnt), .offDone(offDone), .ackFlag(ackFlag),
    .modeVerify(modeVerify), .cycleEn(cycleEn), .success(success),
    .pktByte0(pktByte0), .pktByte1(pktByte1), .pktByte2(pktByte2)
  );

  assign pktValid     = offer;
  assign pktKind      = kind;
  assign busy         = (state != ST_IDLE) && (state != ST_DONE);
  assign done         = (state == ST_DONE);
  assign longPreamble = busy;
  assign trackPowerEn = busy && (state != ST_OFF);

endmodule

// File: rtl/svc_prog_seq_chk.sv
module svc_prog_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       start,
  input logic       pktReady,
  input logic       pktValid,
  input logic [2:0] pktKind,
  input logic [7:0] pktByte0,
  input logic [7:0] pktByte1,
  input logic [7:0] pktByte2,
  input logic       longPreamble,
  input logic       trackPowerEn,
  input logic       busy,
  input logic       done,
  input logic       success
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!pktValid && !trackPowerEn));

  p_off_silent_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !trackPowerEn) |-> !pktValid);

  p_check_byte_r3: assert property (@(posedge clk) disable iff (!rstN)
    pktValid |-> (pktByte2 == (pktByte0 ^ pktByte1)));

  p_long_preamble_r9: assert property (@(posedge clk) disable iff (!rstN)
    pktValid |-> longPreamble);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (pktValid && !pktReady) |=> (pktValid && $stable(pktKind) && $stable(pktByte0)
                                 && $stable(pktByte1) && $stable(pktByte2)));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

  p_success_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(success));

endmodule

bind svc_prog_seq svc_prog_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .start(start), .pktReady(pktReady), .pktValid(pktValid),
  .pktKind(pktKind), .pktByte0(pktByte0), .pktByte1(pktByte1), .pktByte2(pktByte2),
  .longPreamble(longPreamble), .trackPowerEn(trackPowerEn), .busy(busy),
  .done(done), .success(success)
);

// File: tb/svc_prog_seq_test.sv
module svc_prog_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int N_PWR = 20, N_RST = 3, N_PAGE = 11, N_PROG = 5, N_TAIL = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic progVerify = 1'b0;
  logic pwrCycleEn = 1'b0;
  logic [7:0] offClocks = 8'd0;
  logic [7:0] regValue = 8'd0;
  logic ack = 1'b0;
  logic pktReady = 1'b0;
  logic pktValid, longPreamble, trackPowerEn, busy, done, success;
  logic [2:0] pktKind;
  logic [7:0] pktByte0, pktByte1, pktByte2;

  svc_prog_seq uut (
    .clk(clk), .rstN(rstN), .start(start), .progVerify(progVerify), .pwrCycleEn(pwrCycleEn),
    .offClocks(offClocks), .regValue(regValue), .ack(ack), .pktReady(pktReady),
    .pktValid(pktValid), .pktKind(pktKind), .pktByte0(pktByte0), .pktByte1(pktByte1),
    .pktByte2(pktByte2), .longPreamble(longPreamble), .trackPowerEn(trackPowerEn),
    .busy(busy), .done(done), .success(success)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  int readyMode = 0, ackAt = 0, nWr = 0, progK = 3;
  bit monOn = 0, cut = 0;
  int nAcc, wrCnt, idleCnt, offSeen, doneSeen, preBad, holdBad;
  int mmHead, mmMid, mmPost, payBad;
  bit holdPend;
  logic [2:0] hK;
  logic [7:0] h0, h1, h2;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int expKind(input int idx);
    if (idx < N_PWR) return 0;
    if (idx < N_PWR + N_RST) return 1;
    if (idx < N_PWR + N_RST + N_PAGE) return 2;
    if (idx < N_PWR + 2*N_RST + N_PAGE) return 1;
    if (idx < N_PWR + 2*N_RST + N_PAGE + nWr) return progK;
    return cut ? 1 : progK;
  endfunction

  // serializer model, acknowledge source and monitor
  always @(negedge clk) begin
    cyc++;
    case (readyMode)
      0: pktReady = 1'b1;
      1: pktReady = cyc[0];
      default: pktReady = (cyc % 3 == 0);
    endcase
    ack = 1'b0;
    if (monOn) begin
      if (busy && !trackPowerEn) offSeen++;
      if (done) doneSeen++;
      if (pktValid && !longPreamble) preBad++;
      if (holdPend && (!pktValid || pktKind != hK || pktByte0 != h0 || pktByte1 != h1 || pktByte2 != h2))
        holdBad++;
      holdPend = pktValid && !pktReady;
      hK = pktKind; h0 = pktByte0; h1 = pktByte1; h2 = pktByte2;
      if (pktValid && pktReady) begin
        automatic int ek = expKind(nAcc);
        automatic logic [7:0] e0, e1;
        if (int'(pktKind) != ek) begin
          if (nAcc < N_PWR) mmHead++;
          else if (nAcc < N_PWR + N_RST + N_PAGE) mmMid++;
          else mmPost++;
        end
        case (int'(pktKind))
          0: begin e0 = 8'hFF; e1 = 8'h00; end
          1: begin e0 = 8'h00; e1 = 8'h00; end
          2: begin e0 = 8'h7D; e1 = 8'h01; end
          3: begin e0 = 8'h78; e1 = regValue; end
          default: begin e0 = 8'h70; e1 = regValue; end
        endcase
        if (pktByte0 != e0 || pktByte1 != e1 || pktByte2 != (e0 ^ e1)) payBad++;
        if (pktKind == 3'd0) idleCnt++;
        if (pktKind == 3'd3 || pktKind == 3'd4) begin
          wrCnt++;
          if (wrCnt == ackAt) ack = 1'b1;
        end
        nAcc++;
      end
    end
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run(input bit ver, input bit cycEnArg, input int offArg, input int ackArg,
                     input int rm, input logic [7:0] val);
    int guard;
    int expOff, expTotal;
    bit expSucc;
    @(negedge clk);
    progVerify = ver; pwrCycleEn = cycEnArg; offClocks = 8'(offArg); regValue = val;
    readyMode = rm; ackAt = ackArg; progK = ver ? 4 : 3;
    cut = (ackArg >= 1 && ackArg <= N_PROG);
    nWr = cut ? ackArg : N_PROG;
    expSucc = (ackArg >= 1 && ackArg <= N_PROG + N_TAIL);
    expOff = cycEnArg ? ((offArg == 0) ? 1 : offArg) : 0;
    expTotal = N_PWR + 2*N_RST + N_PAGE + nWr + N_TAIL;
    nAcc = 0; wrCnt = 0; idleCnt = 0; offSeen = 0; doneSeen = 0; preBad = 0; holdBad = 0;
    mmHead = 0; mmMid = 0; mmPost = 0; payBad = 0; holdPend = 0;
    monOn = 1;
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (25) @(negedge clk);
    start = 1'b1;                       // R12: must be ignored
    @(negedge clk); start = 1'b0;
    guard = 0;
    while (!done && guard < 5000) begin @(negedge clk); guard++; end
    @(negedge clk);
    monOn = 0;
    check(mmHead == 0, "R2 power-up idle packets", mmHead, 0);
    check(mmMid == 0, "R3 reset and page-preset order", mmMid, 0);
    check(mmPost == 0, cut ? "R7 sequence after cut" : "R6 R8 sequence program and tail",
          mmPost, 0);
    check(payBad == 0, "R5 payload bytes", payBad, 0);
    check(nAcc == expTotal, cut ? "R7 packet total" : "R6 packet total", nAcc, expTotal);
    check(offSeen == expOff, "R4 power-off clocks", offSeen, expOff);
    check(success == expSucc, (ackArg > N_PROG) ? "R8 success" : "R7 R6 success",
          success, expSucc);
    check(doneSeen == 1, "R11 done pulse count", doneSeen, 1);
    check(!busy && !done, "R11 idle after done", busy, 0);
    check(preBad == 0, "R9 long preamble", preBad, 0);
    check(holdBad == 0, "R10 hold under stall", holdBad, 0);
    check(idleCnt == N_PWR, "R12 start while busy ignored", idleCnt, N_PWR);
  endtask

  initial begin
    int runIdx;
    int ackList[8] = '{0, 1, 3, 5, 6, 12, 15, 16};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done && !pktValid && !trackPowerEn, "R1 reset state",
          {busy, done, pktValid, trackPowerEn}, 0);
    runIdx = 0;
    for (int rm = 0; rm < 3; rm++) begin
      for (int a = 0; a < 8; a++) begin
        run(runIdx[0], runIdx[1] ^ runIdx[0], runIdx % 5, ackList[a], rm, 8'(8'h35 + runIdx * 7));
        runIdx++;
      end
    end
    // R11: success holds while idle
    repeat (4) @(negedge clk);
    check(success == 1'b0, "R11 success held while idle", success, 0);
    check(!pktValid && !trackPowerEn, "R1 quiet between runs", pktValid, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule